// File: doc/BRIEF.md
# Byte-Serial Sponge Authenticated-Encryption Mode Wrapper

This block runs a sponge-style authenticated-encryption mode around an external 128-bit block cipher, one byte at a time. It keeps one 128-bit state register. Between cipher calls the host pushes bytes into it together with a command. Each accepted byte is mixed into the state at its byte position and returns one output byte. The first state byte is the most significant one. The rate is 64 bits, so the upper eight state bytes carry data and the lower eight are passed through untouched. The exception is the nonce command, which covers fifteen bytes.

When the last byte a command needs has arrived, the block XORs a domain-separation constant into the final state byte, puts the state on the cipher input and raises a one-cycle start strobe. It then refuses further bytes until the cipher reports done, and at that point the cipher output becomes the new state. Ciphertext, recovered plaintext and the tag all come out of a single XOR lane. Padding, key loading and tag comparison are handled by the host.

Top module: `aem_wrap`

## Requirements
- R1: After reset, `ready_o` is 1, `start_o` is 0, `dout_o` is 0 and the state (seen on `blk_in_o`) is all zeros.
- R2: Command ENC (code 2, 8 bytes): for byte k, `dout_o` = din ^ state byte k, and that result replaces state byte k. The lower 8 bytes are kept, and the last byte is then XORed with 8'h03.
- R3: Command DEC (code 4, 8 bytes): `dout_o` = din ^ state byte k, and the input byte itself replaces state byte k. The last byte is XORed with 8'h03.
- R4: Command INIT (code 1, 8 bytes): feedback from the state is forced to zero, so `dout_o` = din and state byte k = din. At the call, the lower 8 bytes are zero except the last byte, which equals 8'h01.
- R5: Command NONCE (code 3, 15 bytes): state byte k becomes din ^ state byte k, which is also the output. The untouched last byte is XORed with 8'h02, and the call starts only after the fifteenth byte.
- R6: Command TAG (code 5, 16 bytes): `dout_o` = din ^ state byte k. The state is not changed and no cipher call starts.
- R7: `start_o` is high for exactly the one cycle after the final byte of an ENC, DEC, INIT or NONCE block is accepted. `blk_in_o` holds the state and stays stable until done.
- R8: From the start strobe until the edge at which `done_i` is seen, `ready_o` is 0. A push held during that time is stalled and changes nothing.
- R9: With `done_i` high while busy, `blk_out_i` is loaded as the new state and `ready_o` returns to 1 on the next cycle.
- R10: `dout_o` changes only on the clock edge that accepts a push, and holds its value otherwise.
- R11: A push whose command at byte 0 is not a code from 1 to 5 is ignored. The output, state and byte position are all unchanged.
- R12: The command is latched at byte 0 of a block. Changes to `cmd_i` on the following bytes of that block are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push one byte (taken when `ready_o` is 1) |
| cmd_i | input | 3 | Command code, sampled on byte 0 of a block |
| din_i | input | 8 | Input byte |
| ready_o | output | 1 | Block can accept a byte |
| dout_o | output | 8 | Output byte for the last accepted push |
| start_o | output | 1 | One-cycle cipher start strobe |
| blk_in_o | output | 128 | Cipher input block (the state) |
| done_i | input | 1 | Cipher result valid |
| blk_out_i | input | 128 | Cipher output block |

## Verification
An output byte is registered on the same rising edge that accepts its push, so the bench checks `dout_o` at the falling edge that follows. `start_o` and the updated `blk_in_o` appear after the edge that takes the final byte of a block, and they are checked at that same falling edge. The bench also checks that `start_o` has dropped one cycle later. `ready_o` stays low through every cycle of the modeled cipher latency and is checked high at the falling edge after the `done_i` edge. The cipher load itself is then confirmed through a following TAG block.

// File: rtl/aem_pkg.sv
package aem_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_INIT  = 3'd1,
        CMD_ENC   = 3'd2,
        CMD_NONCE = 3'd3,
        CMD_DEC   = 3'd4,
        CMD_TAG   = 3'd5
    } aem_cmd_e;

    function automatic logic cmd_known(input logic [2:0] c);
        return (c == CMD_INIT) || (c == CMD_ENC) || (c == CMD_NONCE) ||
               (c == CMD_DEC)  || (c == CMD_TAG);
    endfunction

endpackage

// File: rtl/aem_seq.sv
module aem_seq
    import aem_pkg::*;
#(
    parameter  int NBYTES      = 16,
    parameter  int RATE_BYTES  = 8,
    parameter  int NONCE_BYTES = 15,
    localparam int IDX_W       = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [2:0]       cmd_i,
    input  logic             done_i,
    output logic             ready_o,
    output logic             accept_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [2:0]       cmd_o,
    output logic             start_o,
    output logic             busy_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [2:0]       cmd;
        logic             busy;
        logic             start;
    } seq_t;

    seq_t r_q, r_d;

    logic [2:0]       eff_cmd;
    logic [IDX_W-1:0] lim_m1;
    logic             acc;
    logic             last;

    always_comb begin
        eff_cmd = (r_q.idx == '0) ? cmd_i : r_q.cmd;
        case (eff_cmd)
            CMD_NONCE: lim_m1 = IDX_W'(NONCE_BYTES - 1);
            CMD_TAG:   lim_m1 = IDX_W'(NBYTES - 1);
            default:   lim_m1 = IDX_W'(RATE_BYTES - 1);
        endcase
        acc  = push_i && !r_q.busy && cmd_known(eff_cmd);
        last = acc && (r_q.idx == lim_m1);

        r_d       = r_q;
        r_d.start = 1'b0;
        if (acc) begin
            if (r_q.idx == '0) begin
                r_d.cmd = eff_cmd;
            end
            r_d.idx = last ? '0 : r_q.idx + 1'b1;
            if (last && (eff_cmd != CMD_TAG)) begin
                r_d.busy  = 1'b1;
                r_d.start = 1'b1;
            end
        end
        if (r_q.busy && done_i) begin
            r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o  = !r_q.busy;
    assign accept_o = acc;
    assign last_o   = last;
    assign idx_o    = r_q.idx;
    assign cmd_o    = eff_cmd;
    assign start_o  = r_q.start;
    assign busy_o   = r_q.busy;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |=> !r_q.start);                                   // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |-> r_q.busy);                                     // R7
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> !acc);                                          // R8
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && done_i) |=> !r_q.busy);                         // R9
    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && (r_q.idx == '0) && !cmd_known(cmd_i)) |=> (r_q.idx == '0)); // R11

endmodule

// File: rtl/aem_lane.sv
module aem_lane
    import aem_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   cmd_i,
    input  logic [W-1:0] din_i,
    input  logic [W-1:0] st_i,
    output logic [W-1:0] dout_o,
    output logic [W-1:0] wr_o
);

    logic [W-1:0] fb;

    always_comb begin
        // INIT masks the state feedback with AND gating
        fb     = st_i & {W{cmd_i != CMD_INIT}};
        dout_o = din_i ^ fb;
        // DEC stores the incoming ciphertext byte, all others the XOR result
        wr_o   = (cmd_i == CMD_DEC) ? din_i : dout_o;
    end

endmodule

// File: rtl/aem_state.sv
module aem_state #(
    parameter  int NBYTES     = 16,
    parameter  int RATE_BYTES = 8,
    parameter  int W          = 8,
    localparam int IDX_W      = $clog2(NBYTES),
    localparam int BLK_W      = NBYTES * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     wr_byte_i,
    input  logic             dom_en_i,
    input  logic [W-1:0]     dom_i,
    input  logic             clr_low_i,
    input  logic             load_i,
    input  logic [BLK_W-1:0] load_data_i,
    output logic [BLK_W-1:0] st_o,
    output logic [W-1:0]     rd_byte_o
);

    // element g holds stream byte NBYTES-1-g (byte 0 is most significant)
    logic [W-1:0]     st_q [NBYTES];
    logic [W-1:0]     st_d [NBYTES];
    logic [IDX_W-1:0] rd_pos;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        localparam int   K       = NBYTES - 1 - g;
        localparam logic IS_LOW  = (K >= RATE_BYTES);
        localparam logic IS_LAST = (K == NBYTES - 1);
        logic [W-1:0] nxt;

        always_comb begin
            nxt = st_q[g];
            if (load_i) begin
                nxt = load_data_i[g*W +: W];
            end else begin
                if (clr_low_i && IS_LOW) begin
                    nxt = '0;
                end
                if (wr_en_i && (idx_i == IDX_W'(K))) begin
                    nxt = wr_byte_i;
                end
                if (dom_en_i && IS_LAST) begin
                    nxt = nxt ^ dom_i;
                end
            end
            st_d[g] = nxt;
        end

        assign st_o[g*W +: W] = st_q[g];
    end

    always_comb begin
        rd_pos    = IDX_W'(NBYTES - 1) - idx_i;
        rd_byte_o = st_q[rd_pos];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < NBYTES; i++) st_q[i] <= st_d[i];
        end
    end

    AST_LOAD_TAKES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_o == $past(load_data_i)));                    // R9

endmodule

// File: rtl/aem_wrap.sv
module aem_wrap
    import aem_pkg::*;
#(
    parameter  int         NBYTES      = 16,
    parameter  int         RATE_BYTES  = 8,
    parameter  int         NONCE_BYTES = 15,
    parameter  int         W           = 8,
    parameter  logic [7:0] DOM_AD      = 8'h01,
    parameter  logic [7:0] DOM_NONCE   = 8'h02,
    parameter  logic [7:0] DOM_MSG     = 8'h03,
    localparam int         IDX_W       = $clog2(NBYTES),
    localparam int         BLK_W       = NBYTES * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [2:0]       cmd_i,
    input  logic [W-1:0]     din_i,
    output logic             ready_o,
    output logic [W-1:0]     dout_o,
    output logic             start_o,
    output logic [BLK_W-1:0] blk_in_o,
    input  logic             done_i,
    input  logic [BLK_W-1:0] blk_out_i
);

    typedef struct packed {
        logic [W-1:0] dout;
    } wrap_t;

    wrap_t r_q, r_d;

    logic             acc, last, busy, load;
    logic [IDX_W-1:0] idx;
    logic [2:0]       cmd;
    logic [W-1:0]     st_byte, lane_dout, lane_wr, dom;
    logic             wr_en, dom_en, clr_low, is_tag;

    aem_seq #(
        .NBYTES     (NBYTES),
        .RATE_BYTES (RATE_BYTES),
        .NONCE_BYTES(NONCE_BYTES)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .cmd_i   (cmd_i),
        .done_i  (done_i),
        .ready_o (ready_o),
        .accept_o(acc),
        .last_o  (last),
        .idx_o   (idx),
        .cmd_o   (cmd),
        .start_o (start_o),
        .busy_o  (busy)
    );

    aem_lane #(.W(W)) i_lane (
        .cmd_i (cmd),
        .din_i (din_i),
        .st_i  (st_byte),
        .dout_o(lane_dout),
        .wr_o  (lane_wr)
    );

    always_comb begin
        is_tag  = (cmd == CMD_TAG);
        wr_en   = acc && !is_tag;
        dom_en  = last && !is_tag;
        clr_low = last && (cmd == CMD_INIT);
        load    = busy && done_i;
        case (cmd)
            CMD_INIT:  dom = DOM_AD;
            CMD_NONCE: dom = DOM_NONCE;
            default:   dom = DOM_MSG;
        endcase
        r_d      = r_q;
        if (acc) begin
            r_d.dout = lane_dout;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    aem_state #(
        .NBYTES    (NBYTES),
        .RATE_BYTES(RATE_BYTES),
        .W         (W)
    ) i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .idx_i      (idx),
        .wr_byte_i  (lane_wr),
        .dom_en_i   (dom_en),
        .dom_i      (dom),
        .clr_low_i  (clr_low),
        .load_i     (load),
        .load_data_i(blk_out_i),
        .st_o       (blk_in_o),
        .rd_byte_o  (st_byte)
    );

    assign dout_o = r_q.dout;

    AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_i) |=> $stable(blk_in_o));                    // R7
    AST_START_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_o);                                    // R7
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done_i) |=> ready_o);                               // R9
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(dout_o));                                   // R10
    AST_TAG_NO_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_tag) |=> (!start_o && $stable(blk_in_o)));        // R6

endmodule

// File: tb/test_aem_wrap.sv
module test_aem_wrap;
    import aem_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;
    localparam int WD_CYCLES  = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0;
    logic [2:0]   cmd_i = 3'd0;
    logic [7:0]   din_i = 8'h00;
    logic         ready_o;
    logic [7:0]   dout_o;
    logic         start_o;
    logic [127:0] blk_in_o;
    logic         done_i = 1'b0;
    logic [127:0] blk_out_i = '0;

    int checks = 0;
    int errors = 0;
    logic [127:0] mst = '0;   // bench model of the state
    logic summary_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aem_wrap i_aem_wrap (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .cmd_i    (cmd_i),
        .din_i    (din_i),
        .ready_o  (ready_o),
        .dout_o   (dout_o),
        .start_o  (start_o),
        .blk_in_o (blk_in_o),
        .done_i   (done_i),
        .blk_out_i(blk_out_i)
    );

    function automatic logic [127:0] cipher_model(input logic [127:0] x);
        return {x[100:0], x[127:101]} ^ 128'h5A3C_96E1_0F87_D24B_1E2D_3C4B_5A69_7887;
    endfunction

    function automatic logic [7:0] byte_of(input logic [127:0] v, input int k);
        return v[127-8*k -: 8];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_cipher(input logic [127:0] blk, input string req);
        // keep a push pending during the call to test stalling (R8)
        push_i = 1'b1;
        cmd_i  = CMD_ENC;
        din_i  = 8'hEE;
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            check("R8", "ready low while busy", 128'(ready_o), 128'd0);
            check("R7", "start single cycle", 128'(start_o), 128'd0);
        end
        done_i    = 1'b1;
        blk_out_i = cipher_model(blk);
        @(negedge clk);
        done_i = 1'b0;
        push_i = 1'b0;
        check(req, "ready back after done (R9)", 128'(ready_o), 128'd1);
        mst = cipher_model(blk);
    endtask

    // one block of n pushes; c on byte 0, c_late on the others
    task automatic run_block(input logic [2:0] c, input logic [2:0] c_late,
                             input logic [127:0] data, input int n,
                             input logic [7:0] dom, input string req);
        logic [127:0] nxt;
        logic [7:0]   d, fb, e;
        logic         calls;
        calls = (c != CMD_TAG);
        nxt   = mst;
        if (c == CMD_INIT) nxt[63:0] = '0;
        for (int k = 0; k < n; k++) begin
            d  = byte_of(data, k);
            fb = (c == CMD_INIT) ? 8'h00 : byte_of(mst, k);
            e  = d ^ fb;
            @(negedge clk);
            push_i = 1'b1;
            cmd_i  = (k == 0) ? c : c_late;
            din_i  = d;
            @(negedge clk);
            push_i = 1'b0;
            check(req, "output byte", 128'(dout_o), 128'(e));
            if (c != CMD_TAG) nxt[127-8*k -: 8] = (c == CMD_DEC) ? d : e;
            if (k < n - 1 || !calls)
                check("R7", "no start before final byte", 128'(start_o), 128'd0);
        end
        if (calls) begin
            nxt[7:0] = nxt[7:0] ^ dom;
            check("R7", "start after final byte", 128'(start_o), 128'd1);
            check(req, "cipher input block", blk_in_o, nxt);
            run_cipher(nxt, "R9");
        end else begin
            check("R6", "state unchanged by tag", blk_in_o, mst);
        end
    endtask

    task automatic t_reset;
        check("R1", "ready after reset", 128'(ready_o), 128'd1);
        check("R1", "start after reset", 128'(start_o), 128'd0);
        check("R1", "dout after reset", 128'(dout_o), 128'd0);
        check("R1", "state after reset", blk_in_o, 128'd0);
    endtask

    task automatic t_dout_hold;
        logic [7:0] held;
        held = dout_o;
        repeat (3) @(negedge clk);
        check("R10", "dout holds without push", 128'(dout_o), 128'(held));
    endtask

    task automatic t_unknown_cmd;
        logic [7:0] held;
        held = dout_o;
        @(negedge clk);
        push_i = 1'b1;
        cmd_i  = 3'd6;
        din_i  = 8'hAA;
        @(negedge clk);
        push_i = 1'b0;
        check("R11", "dout unchanged by unknown command", 128'(dout_o), 128'(held));
        check("R11", "state unchanged by unknown command", blk_in_o, mst);
        // a full tag block proves the byte position was not advanced
        run_block(CMD_TAG, CMD_TAG, 128'h0, 16, 8'h00, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_block(CMD_TAG, CMD_TAG, 128'h00112233_44556677_8899AABB_CCDDEEFF, 16, 8'h00, "R6");
        t_dout_hold();
        run_block(CMD_INIT, CMD_INIT, 128'hA1B2C3D4_E5F60718_00000000_00000000, 8, 8'h01, "R4");
        run_block(CMD_TAG, CMD_TAG, 128'h0, 16, 8'h00, "R9");
        run_block(CMD_TAG, CMD_TAG, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 16, 8'h00, "R6");
        run_block(CMD_ENC, CMD_ENC, 128'h0F1E2D3C_4B5A6978_00000000_00000000, 8, 8'h03, "R2");
        run_block(CMD_NONCE, CMD_NONCE, 128'h10203040_50607080_90A0B0C0_D0E0F000, 15, 8'h02, "R5");
        run_block(CMD_DEC, CMD_DEC, 128'hCAFEBABE_DEADBEEF_00000000_00000000, 8, 8'h03, "R3");
        run_block(CMD_ENC, CMD_DEC, 128'h55AA55AA_33CC33CC_00000000_00000000, 8, 8'h03, "R12");
        t_unknown_cmd();
        run_block(CMD_TAG, CMD_TAG, 128'h0, 16, 8'h00, "R9");
        t_dout_hold();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule